// File: doc/BRIEF.md
# Unclaimed Transaction Sink

This block is the last stop for transactions that the routing fabric could not deliver to any agent. Each arriving descriptor carries a kind code, the requester ID, a tag, a length in 4-byte words and an address. A read is answered with a completion whose status is Unsupported Request. The completion echoes the requester ID and tag, carries no data and reports a byte count of zero. Writes, completions and the reserved kind are consumed without any response.

Every accepted descriptor is an error event. An error log captures the kind, requester ID, address and an oversize flag of the first event seen while its status bit is clear. A counter tallies all events and saturates. The oversize flag marks traffic that integrated devices could not take: an address beyond 36 bits or a payload above 64 bytes. Two clear inputs, active for one cycle each, act as write-one-to-clear strobes for the status and for the counter. A level interrupt output follows the status bit.

The input stalls only when a read arrives while an earlier Unsupported Request completion still waits on the output. Every other kind is accepted in the cycle it is offered.

Top module: `unclaimed_txn_sink`

## Requirements
- R1: An accepted read (kind 2'b00) produces exactly one completion on the next cycle. It echoes the requester ID and tag, carries status 3'b001 (Unsupported Request) and has a byte count of zero.
- R2: Kinds 2'b01 (write), 2'b10 (completion) and 2'b11 (reserved) are accepted in the cycle they are offered (in_ready high) and never produce a completion.
- R3: While a completion is held and cpl_ready is low, a read is stalled (in_ready low) and the completion's fields stay unchanged until it is taken.
- R4: While the status bit is clear, an event sets it and captures kind, requester ID, address and oversize flag. While the bit is set, later events leave the captured fields unchanged.
- R5: The oversize flag is set when any address bit at position 36 or above is 1, or when the payload exceeds 64 bytes. The payload is in_len 4-byte words, and in_len = 0 means 1024 words.
- R6: The event counter adds one for every accepted descriptor and stops at all ones (255 by default).
- R7: clr_status clears the status bit and the captured fields to zero. If an event is accepted in the same cycle, that event is captured instead. clr_count zeroes the counter, or sets it to 1 if an event is accepted in the same cycle.
- R8: err_irq is high exactly when the status bit is set.
- R9: After reset, in_ready is high, no completion is offered, the status bit is clear, the counter is zero and err_irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Descriptor offered |
| in_ready | output | 1 | Descriptor accepted this cycle when valid |
| in_kind | input | 2 | 00 read, 01 write, 10 completion, 11 reserved |
| in_src_id | input | 16 | Requester ID |
| in_tag | input | 8 | Transaction tag |
| in_len | input | 10 | Length in 4-byte words, 0 means 1024 |
| in_addr | input | 48 | Transaction address |
| cpl_valid | output | 1 | Unsupported Request completion offered |
| cpl_ready | input | 1 | Completion taken this cycle when valid |
| cpl_req_id | output | 16 | Echoed requester ID |
| cpl_tag | output | 8 | Echoed tag |
| cpl_status | output | 3 | Completion status, 3'b001 |
| cpl_byte_cnt | output | 12 | Byte count, always zero |
| clr_status | input | 1 | Write-one-to-clear strobe for the status and captured fields |
| clr_count | input | 1 | Write-one-to-clear strobe for the event counter |
| log_valid | output | 1 | Sticky status bit |
| log_kind | output | 2 | Kind of the captured event |
| log_src_id | output | 16 | Requester ID of the captured event |
| log_addr | output | 48 | Address of the captured event |
| log_oversize | output | 1 | Oversize flag of the captured event |
| log_count | output | 8 | Saturating event counter |
| err_irq | output | 1 | Level error interrupt |

## Verification
A stale or lost completion register shows at the ports on the cycle after the read that should have loaded it, as a missing or wrong tag. It can also show as an in_ready that stays low for a read with nothing pending. A capture that fires on the wrong condition overwrites the logged fields on the very next event while the status bit is set. The counter is compared on every cycle, so a missed increment or a wrap at all ones appears one cycle after the event that caused it. The oversize flag is checked right after capture, with addresses and lengths placed just below and just above each limit.

// File: rtl/unk_pkg.sv
package unk_pkg;
   typedef enum logic [1:0] {
      KIND_RD  = 2'b00,
      KIND_WR  = 2'b01,
      KIND_CPL = 2'b10,
      KIND_RSV = 2'b11
   } kind_e;

   localparam logic [2:0] CPL_ST_UR = 3'b001;
endpackage

// File: rtl/unk_classify.sv
module unk_classify #(
   parameter int ADDR_W        = 48,
   parameter int LEN_W         = 10,
   parameter int NARROW_AW     = 36,
   parameter int MAX_PAYLOAD_B = 64
) (
   input  logic [1:0]        kind,
   input  logic [ADDR_W-1:0] addr,
   input  logic [LEN_W-1:0]  len,
   output logic              is_read,
   output logic              oversize
);
   import unk_pkg::*;

   localparam int MAX_DW = MAX_PAYLOAD_B / 4;
   localparam logic [LEN_W:0] MAX_DW_V = (LEN_W+1)'(MAX_DW);
   localparam logic [LEN_W:0] FULL_DW  = (LEN_W+1)'(1) << LEN_W;

   logic             addr_wide;
   logic [LEN_W:0]   words;

   generate
      if (ADDR_W > NARROW_AW) begin : g_wide
         assign addr_wide = |addr[ADDR_W-1:NARROW_AW];
      end else begin : g_narrow
         assign addr_wide = 1'b0;
      end
   endgenerate

   always_comb begin
      words    = (len == '0) ? FULL_DW : {1'b0, len};
      is_read  = (kind == KIND_RD);
      oversize = addr_wide || (words > MAX_DW_V);
   end
endmodule

// File: rtl/unk_resp.sv
module unk_resp #(
   parameter int ID_W  = 16,
   parameter int TAG_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [ID_W-1:0]  ld_id,
   input  logic [TAG_W-1:0] ld_tag,
   output logic             can_accept,
   output logic             cpl_valid,
   input  logic             cpl_ready,
   output logic [ID_W-1:0]  cpl_id,
   output logic [TAG_W-1:0] cpl_tag
);
   assign can_accept = !cpl_valid || cpl_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cpl_valid <= 1'b0;
         cpl_id    <= '0;
         cpl_tag   <= '0;
      end else if (load) begin
         cpl_valid <= 1'b1;
         cpl_id    <= ld_id;
         cpl_tag   <= ld_tag;
      end else if (cpl_ready) begin
         cpl_valid <= 1'b0;
      end
   end
endmodule

// File: rtl/unk_log.sv
module unk_log #(
   parameter int ADDR_W   = 48,
   parameter int ID_W     = 16,
   parameter int CNT_W    = 8,
   parameter bit SATURATE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ev,
   input  logic [1:0]        ev_kind,
   input  logic [ID_W-1:0]   ev_id,
   input  logic [ADDR_W-1:0] ev_addr,
   input  logic              ev_over,
   input  logic              clr_status,
   input  logic              clr_count,
   output logic              log_valid,
   output logic [1:0]        log_kind,
   output logic [ID_W-1:0]   log_id,
   output logic [ADDR_W-1:0] log_addr,
   output logic              log_over,
   output logic [CNT_W-1:0]  log_count
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   logic             capture;
   logic [CNT_W-1:0] cnt_inc;

   assign capture = ev && (!log_valid || clr_status);

   generate
      if (SATURATE) begin : g_sat
         assign cnt_inc = (log_count == CNT_MAX) ? log_count : log_count + CNT_ONE;
      end else begin : g_wrap
         assign cnt_inc = log_count + CNT_ONE;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         log_valid <= 1'b0;
         log_kind  <= '0;
         log_id    <= '0;
         log_addr  <= '0;
         log_over  <= 1'b0;
      end else if (capture) begin
         log_valid <= 1'b1;
         log_kind  <= ev_kind;
         log_id    <= ev_id;
         log_addr  <= ev_addr;
         log_over  <= ev_over;
      end else if (clr_status) begin
         log_valid <= 1'b0;
         log_kind  <= '0;
         log_id    <= '0;
         log_addr  <= '0;
         log_over  <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         log_count <= '0;
      else if (clr_count) log_count <= ev ? CNT_ONE : '0;
      else if (ev)        log_count <= cnt_inc;
   end
endmodule

// File: rtl/unclaimed_txn_sink.sv
module unclaimed_txn_sink #(
   parameter int ADDR_W        = 48,
   parameter int ID_W          = 16,
   parameter int TAG_W         = 8,
   parameter int LEN_W         = 10,
   parameter int BC_W          = 12,
   parameter int CNT_W         = 8,
   parameter int NARROW_AW     = 36,
   parameter int MAX_PAYLOAD_B = 64,
   parameter bit SATURATE      = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [1:0]        in_kind,
   input  logic [ID_W-1:0]   in_src_id,
   input  logic [TAG_W-1:0]  in_tag,
   input  logic [LEN_W-1:0]  in_len,
   input  logic [ADDR_W-1:0] in_addr,
   output logic              cpl_valid,
   input  logic              cpl_ready,
   output logic [ID_W-1:0]   cpl_req_id,
   output logic [TAG_W-1:0]  cpl_tag,
   output logic [2:0]        cpl_status,
   output logic [BC_W-1:0]   cpl_byte_cnt,
   input  logic              clr_status,
   input  logic              clr_count,
   output logic              log_valid,
   output logic [1:0]        log_kind,
   output logic [ID_W-1:0]   log_src_id,
   output logic [ADDR_W-1:0] log_addr,
   output logic              log_oversize,
   output logic [CNT_W-1:0]  log_count,
   output logic              err_irq
);
   import unk_pkg::*;

   generate
      if (ADDR_W < 1 || ID_W < 1 || TAG_W < 1 || LEN_W < 1 || CNT_W < 1) begin : g_bad_w
         $error("unclaimed_txn_sink: all widths must be positive");
      end
      if (MAX_PAYLOAD_B < 4 || (MAX_PAYLOAD_B % 4) != 0) begin : g_bad_pl
         $error("unclaimed_txn_sink: payload limit must be a positive multiple of 4");
      end
      if (NARROW_AW < 1) begin : g_bad_aw
         $error("unclaimed_txn_sink: narrow address width must be positive");
      end
   endgenerate

   logic is_read;
   logic oversize;
   logic can_accept;
   logic fire;

   unk_classify #(
      .ADDR_W(ADDR_W), .LEN_W(LEN_W),
      .NARROW_AW(NARROW_AW), .MAX_PAYLOAD_B(MAX_PAYLOAD_B)
   ) u_cls (
      .kind(in_kind), .addr(in_addr), .len(in_len),
      .is_read(is_read), .oversize(oversize)
   );

   assign in_ready = !is_read || can_accept;
   assign fire     = in_valid && in_ready;

   unk_resp #(.ID_W(ID_W), .TAG_W(TAG_W)) u_resp (
      .clk(clk), .rst_n(rst_n),
      .load(fire && is_read), .ld_id(in_src_id), .ld_tag(in_tag),
      .can_accept(can_accept),
      .cpl_valid(cpl_valid), .cpl_ready(cpl_ready),
      .cpl_id(cpl_req_id), .cpl_tag(cpl_tag)
   );

   assign cpl_status   = CPL_ST_UR;
   assign cpl_byte_cnt = '0;

   unk_log #(
      .ADDR_W(ADDR_W), .ID_W(ID_W), .CNT_W(CNT_W), .SATURATE(SATURATE)
   ) u_log (
      .clk(clk), .rst_n(rst_n),
      .ev(fire), .ev_kind(in_kind), .ev_id(in_src_id),
      .ev_addr(in_addr), .ev_over(oversize),
      .clr_status(clr_status), .clr_count(clr_count),
      .log_valid(log_valid), .log_kind(log_kind), .log_id(log_src_id),
      .log_addr(log_addr), .log_over(log_oversize), .log_count(log_count)
   );

   assign err_irq = log_valid;
endmodule

// File: rtl/unk_checker.sv
module unk_checker #(
   parameter int ID_W     = 16,
   parameter int TAG_W    = 8,
   parameter int CNT_W    = 8,
   parameter bit SATURATE = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic             in_ready,
   input logic [1:0]       in_kind,
   input logic [ID_W-1:0]  in_src_id,
   input logic [TAG_W-1:0] in_tag,
   input logic             cpl_valid,
   input logic             cpl_ready,
   input logic [ID_W-1:0]  cpl_req_id,
   input logic [TAG_W-1:0] cpl_tag,
   input logic             clr_status,
   input logic             clr_count,
   input logic             log_valid,
   input logic [ID_W-1:0]  log_src_id,
   input logic [CNT_W-1:0] log_count,
   input logic             err_irq
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   a_r1_read_makes_cpl: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready && in_kind == 2'b00 |=>
      cpl_valid && cpl_tag == $past(in_tag) && cpl_req_id == $past(in_src_id));

   a_r2_nonread_accepted: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_kind != 2'b00 |-> in_ready);

   a_r3_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
      cpl_valid && !cpl_ready |=> cpl_valid && $stable(cpl_tag) && $stable(cpl_req_id));

   a_r4_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
      log_valid && !clr_status |=> log_valid && $stable(log_src_id));

   a_r6_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready && !clr_count && log_count != CNT_MAX |=>
      log_count == $past(log_count) + CNT_W'(1));

   a_r7_count_clear: assert property (@(posedge clk) disable iff (!rst_n)
      clr_count && !(in_valid && in_ready) |=> log_count == '0);

   a_r8_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_irq) |-> $past(in_valid && in_ready));

   generate
      if (SATURATE) begin : g_sat_chk
         a_r6_count_saturates: assert property (@(posedge clk) disable iff (!rst_n)
            log_count == CNT_MAX && !clr_count |=> log_count == CNT_MAX);
      end
   endgenerate
endmodule

bind unclaimed_txn_sink unk_checker #(
   .ID_W(ID_W), .TAG_W(TAG_W), .CNT_W(CNT_W), .SATURATE(SATURATE)
) u_chk (
   .clk(clk), .rst_n(rst_n),
   .in_valid(in_valid), .in_ready(in_ready), .in_kind(in_kind),
   .in_src_id(in_src_id), .in_tag(in_tag),
   .cpl_valid(cpl_valid), .cpl_ready(cpl_ready),
   .cpl_req_id(cpl_req_id), .cpl_tag(cpl_tag),
   .clr_status(clr_status), .clr_count(clr_count),
   .log_valid(log_valid), .log_src_id(log_src_id),
   .log_count(log_count), .err_irq(err_irq)
);

// File: tb/tb_unclaimed_txn_sink.sv
`timescale 1ns/1ps
module tb_unclaimed_txn_sink;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [1:0]  in_kind = '0;
   logic [15:0] in_src_id = '0;
   logic [7:0]  in_tag = '0;
   logic [9:0]  in_len = '0;
   logic [47:0] in_addr = '0;
   logic        cpl_valid;
   logic        cpl_ready = 1'b0;
   logic [15:0] cpl_req_id;
   logic [7:0]  cpl_tag;
   logic [2:0]  cpl_status;
   logic [11:0] cpl_byte_cnt;
   logic        clr_status = 1'b0;
   logic        clr_count = 1'b0;
   logic        log_valid;
   logic [1:0]  log_kind;
   logic [15:0] log_src_id;
   logic [47:0] log_addr;
   logic        log_oversize;
   logic [7:0]  log_count;
   logic        err_irq;

   always #2.5 clk = ~clk;

   unclaimed_txn_sink dut (.*);

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // model state
   bit          m_cv = 0;
   logic [15:0] m_cid = '0;
   logic [7:0]  m_ctag = '0;
   bit          m_lv = 0;
   logic [1:0]  m_lkind = '0;
   logic [15:0] m_lid = '0;
   logic [47:0] m_laddr = '0;
   bit          m_lover = 0;
   int          m_cnt = 0;

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic bit f_over(input logic [47:0] a, input logic [9:0] l);
      int dw;
      dw = (l == 0) ? 1024 : int'(l);
      return (a[47:36] != 0) || (dw * 4 > 64);
   endfunction

   task automatic compare_outputs();
      chk(cpl_valid == m_cv, "R1 cpl_valid", 64'(cpl_valid), 64'(m_cv));
      if (m_cv) begin
         chk(cpl_tag == m_ctag, "R1 cpl_tag", 64'(cpl_tag), 64'(m_ctag));
         chk(cpl_req_id == m_cid, "R1 cpl_req_id", 64'(cpl_req_id), 64'(m_cid));
         chk(cpl_status == 3'b001, "R1 cpl_status", 64'(cpl_status), 64'd1);
         chk(cpl_byte_cnt == 0, "R1 cpl_byte_cnt", 64'(cpl_byte_cnt), 64'd0);
      end
      chk(log_valid == m_lv, "R4 log_valid", 64'(log_valid), 64'(m_lv));
      chk(log_kind == m_lkind, "R4 log_kind", 64'(log_kind), 64'(m_lkind));
      chk(log_src_id == m_lid, "R4 log_src_id", 64'(log_src_id), 64'(m_lid));
      chk(log_addr == m_laddr, "R4 log_addr", 64'(log_addr), 64'(m_laddr));
      chk(log_oversize == m_lover, "R5 log_oversize", 64'(log_oversize), 64'(m_lover));
      chk(int'(log_count) == m_cnt, "R6 log_count", 64'(log_count), 64'(m_cnt));
      chk(err_irq == m_lv, "R8 err_irq", 64'(err_irq), 64'(m_lv));
   endtask

   task automatic step(input bit v, input logic [1:0] k, input logic [15:0] id,
                       input logic [7:0] tag, input logic [9:0] len, input logic [47:0] addr,
                       input bit rdy, input bit cs, input bit cc);
      bit exp_rdy;
      bit fire;
      @(negedge clk);
      compare_outputs();
      in_valid = v; in_kind = k; in_src_id = id; in_tag = tag;
      in_len = len; in_addr = addr; cpl_ready = rdy;
      clr_status = cs; clr_count = cc;
      #1;
      exp_rdy = (k != 2'b00) || !m_cv || rdy;
      if (k == 2'b00)
         chk(in_ready == exp_rdy, "R3 in_ready read", 64'(in_ready), 64'(exp_rdy));
      else
         chk(in_ready == exp_rdy, "R2 in_ready non-read", 64'(in_ready), 64'(exp_rdy));
      fire = v && exp_rdy;
      // completion slot
      if (fire && k == 2'b00) begin
         m_cv = 1; m_cid = id; m_ctag = tag;
      end else if (m_cv && rdy) begin
         m_cv = 0;
      end
      // log
      if (fire && (!m_lv || cs)) begin
         m_lv = 1; m_lkind = k; m_lid = id; m_laddr = addr; m_lover = f_over(addr, len);
      end else if (cs) begin
         m_lv = 0; m_lkind = '0; m_lid = '0; m_laddr = '0; m_lover = 0;
      end
      // counter
      if (cc) m_cnt = fire ? 1 : 0;
      else if (fire && m_cnt != 255) m_cnt = m_cnt + 1;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R9: reset state while reset is held
      chk(in_ready == 1'b1, "R9 in_ready", 64'(in_ready), 64'd1);
      chk(cpl_valid == 1'b0, "R9 cpl_valid", 64'(cpl_valid), 64'd0);
      chk(log_valid == 1'b0, "R9 log_valid", 64'(log_valid), 64'd0);
      chk(log_count == 0, "R9 log_count", 64'(log_count), 64'd0);
      chk(err_irq == 1'b0, "R9 err_irq", 64'(err_irq), 64'd0);
      rst_n = 1'b1;

      // directed: read held, second read stalls, write passes (R1 R2 R3)
      step(1, 2'b00, 16'h1234, 8'h05, 10'd1, 48'h0_0000_1000, 0, 0, 0);
      step(1, 2'b00, 16'h2222, 8'h06, 10'd1, 48'h0_0000_2000, 0, 0, 0);
      step(1, 2'b01, 16'h3333, 8'h07, 10'd4, 48'h0_0000_3000, 0, 0, 0);
      step(1, 2'b10, 16'h4444, 8'h08, 10'd4, 48'h0_0000_4000, 0, 0, 0);
      step(1, 2'b11, 16'h5555, 8'h09, 10'd4, 48'h0_0000_5000, 1, 0, 0);
      step(0, 2'b00, 16'h0, 8'h0, 10'd0, 48'h0, 1, 0, 0);
      // R7: clear together with event, event is captured; R5 address bit 36
      step(1, 2'b01, 16'hAAAA, 8'h10, 10'd1, 48'h0010_0000_0000, 1, 1, 0);
      step(0, 2'b00, 16'h0, 8'h0, 10'd0, 48'h0, 1, 1, 0);
      // R5: 16 words is exactly 64 bytes, not oversize
      step(1, 2'b01, 16'hBBBB, 8'h11, 10'd16, 48'h0_FFFF_FFFC, 1, 0, 0);
      step(0, 2'b00, 16'h0, 8'h0, 10'd0, 48'h0, 1, 1, 0);
      // R5: 17 words is oversize
      step(1, 2'b10, 16'hCCCC, 8'h12, 10'd17, 48'h0_0000_0040, 1, 0, 0);
      step(0, 2'b00, 16'h0, 8'h0, 10'd0, 48'h0, 1, 1, 0);
      // R5: length 0 means 1024 words
      step(1, 2'b11, 16'hDDDD, 8'h13, 10'd0, 48'h0_0000_0080, 1, 0, 0);
      // R7: counter clear with same-cycle event
      step(1, 2'b01, 16'hEEEE, 8'h14, 10'd1, 48'h0, 1, 0, 1);
      step(0, 2'b00, 16'h0, 8'h0, 10'd0, 48'h0, 1, 0, 1);

      // constrained random
      for (int i = 0; i < 4000; i++) begin
         logic [47:0] a;
         logic [9:0]  l;
         a = {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF;
         if ($urandom % 3 != 0) a[47:36] = '0;
         l = ($urandom % 8 == 0) ? 10'd0 : 10'($urandom % 24);
         step(($urandom % 5) != 0, 2'($urandom), 16'($urandom), 8'($urandom), l, a,
              ($urandom % 5) < 3, ($urandom % 40) == 0, ($urandom % 900) == 0);
      end
      step(0, 2'b00, 16'h0, 8'h0, 10'd0, 48'h0, 1, 0, 0);
      @(negedge clk);
      compare_outputs();

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule